// File: doc/BRIEF.md
# Dual-Port RAM with Mailbox Interrupts

This block is a synchronous true dual-port RAM with two independent ports, called left and right. Each port has its own active-low chip select, active-low output enable, a read/write select (low means write), an address and write data, and it returns read data through a registered output. Both ports may read or write any word in the same cycle.

The two highest addresses can serve as mailboxes between the agents on the two ports. The address one below the top is the left port's inbox: a right-port write there pulls the left interrupt low. The top address is the right port's inbox: a left-port write there pulls the right interrupt low. Each side clears its own interrupt by accessing its inbox. The message itself is an ordinary stored word. A global enable turns the mailbox function on. When it is off, both words are plain storage and neither interrupt ever asserts.

The depth is set by `ADDR_W`. The default of 10 keeps elaboration small. `ADDR_W = 14` with `DATA_W = 16` gives a 16K x 16 array whose inboxes sit at 0x3FFE (left) and 0x3FFF (right).

Top module: `mbox_dpram`

## Requirements
- R1: A port read (select low, read/write high, output enable low) places the word at its address on that port's read data one clock later. At every other edge the read data holds its value.
- R2: A port write (select low, read/write low) stores the write data at its address. A read of that address on the other port in the same cycle returns the word as it was before the write.
- R3: When both ports write the same address in the same cycle, the left port's data is stored.
- R4: A port whose select is high performs no access. It stores nothing, its read data holds, and it neither sets nor clears an interrupt.
- R5: With the mailbox enabled, a right-port write to address 2^ADDR_W-2 drives `l_irq_n` low at the next clock.
- R6: With the mailbox enabled, a left-port access to address 2^ADDR_W-2 with select and output enable both low clears the left interrupt (`l_irq_n` high at the next clock), whatever the read/write level.
- R7: With the mailbox enabled, a left-port write to address 2^ADDR_W-1 drives `r_irq_n` low at the next clock.
- R8: With the mailbox enabled, only a right-port read of address 2^ADDR_W-1 clears the right interrupt. A right-port write to that address leaves the interrupt unchanged.
- R9: If the set and the clear of the same interrupt happen in the same cycle, the interrupt ends up asserted.
- R10: With the mailbox disabled, both interrupts are high one clock later, and the two top words behave as plain storage.
- R11: The interrupts are active low and registered. Reset drives them high and clears both read data outputs to zero.
- R12: Mailbox words keep the data written to them, and either port can read them back like any other word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for both ports |
| rst_n | input | 1 | Synchronous active-low reset |
| mb_enable | input | 1 | 1 enables the mailbox interrupts |
| l_cs_n | input | 1 | Left select, active low |
| l_oe_n | input | 1 | Left output enable, active low |
| l_we_n | input | 1 | Left read/write, 0 = write |
| l_addr | input | ADDR_W | Left address |
| l_wdata | input | DATA_W | Left write data |
| l_rdata | output | DATA_W | Left registered read data |
| l_irq_n | output | 1 | Left interrupt, active low |
| r_cs_n | input | 1 | Right select, active low |
| r_oe_n | input | 1 | Right output enable, active low |
| r_we_n | input | 1 | Right read/write, 0 = write |
| r_addr | input | ADDR_W | Right address |
| r_wdata | input | DATA_W | Right write data |
| r_rdata | output | DATA_W | Right registered read data |
| r_irq_n | output | 1 | Right interrupt, active low |

## Verification
The assertions check the interrupt flags on every cycle: set, clear, set-over-clear priority, hold when idle, forced release when disabled, and the reset value. They also check that read data holds while a port is deselected. Stored values cannot be seen by a property. These are shown only by the bench's scenarios, whose model tracks the array: old-data reads during a write from the other port, the left port winning a same-address write, deselected writes leaving memory untouched, and mailbox words acting as plain data.

// File: rtl/mbox_pkg.sv
// Shared types for the mailbox dual-port RAM.
// Assumes: active-low port controls; read/write select low means write.
package mbox_pkg;
    // Decoded access of one port in the current cycle
    typedef struct packed {
        logic wr;     // select low, read/write low
        logic rd;     // select low, read/write high, output enable low
        logic sel_oe; // select low and output enable low, read/write ignored
    } port_op_t;
endpackage

// File: rtl/port_decode.sv
// Turns one port's control pins into access strobes and mailbox address hits.
// Assumes: mailboxes are the two highest addresses of a 2^AW array.
module port_decode
    import mbox_pkg::*;
#(
    parameter int AW = 10
) (
    input  logic          cs_n,
    input  logic          oe_n,
    input  logic          we_n,
    input  logic [AW-1:0] addr,
    output port_op_t      op,
    output logic          at_box_lo,
    output logic          at_box_hi
);
    localparam logic [AW-1:0] BOX_HI = {AW{1'b1}};
    localparam logic [AW-1:0] BOX_LO = BOX_HI - 1'b1;

    // Classify the access and compare the address with both mailboxes
    always_comb begin
        op.wr     = !cs_n && !we_n;
        op.rd     = !cs_n && we_n && !oe_n;
        op.sel_oe = !cs_n && !oe_n;
        at_box_lo = (addr == BOX_LO);
        at_box_hi = (addr == BOX_HI);
    end
endmodule

// File: rtl/dpram_core.sv
// Storage array with two write ports and two registered read ports.
// Assumes: a read returns pre-write data; the left write wins on a shared address.
module dpram_core #(
    parameter int AW = 10,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          l_wr,
    input  logic          l_rd,
    input  logic [AW-1:0] l_addr,
    input  logic [DW-1:0] l_wdata,
    output logic [DW-1:0] l_rdata,
    input  logic          r_wr,
    input  logic          r_rd,
    input  logic [AW-1:0] r_addr,
    input  logic [DW-1:0] r_wdata,
    output logic [DW-1:0] r_rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];

    // Array update: right first, so a left write to the same word lands last
    always_ff @(posedge clk) begin
        if (r_wr) mem[r_addr] <= r_wdata;
        if (l_wr) mem[l_addr] <= l_wdata;
    end

    // Left read register, cleared by reset, loaded only on a read
    always_ff @(posedge clk) begin
        if (!rst_n)    l_rdata <= '0;
        else if (l_rd) l_rdata <= mem[l_addr];
    end

    // Right read register, cleared by reset, loaded only on a read
    always_ff @(posedge clk) begin
        if (!rst_n)    r_rdata <= '0;
        else if (r_rd) r_rdata <= mem[r_addr];
    end
endmodule

// File: rtl/mbox_flag.sv
// One registered active-low interrupt flag with set priority over clear.
// Assumes: while enable is low the flag is forced to the released state.
module mbox_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic set,
    input  logic clr,
    output logic irq_n
);
    // Flag state: release on reset or disable, set beats clear
    always_ff @(posedge clk) begin
        if (!rst_n || !enable) irq_n <= 1'b1;
        else if (set)          irq_n <= 1'b0;
        else if (clr)          irq_n <= 1'b1;
    end
endmodule

// File: rtl/mbox_dpram.sv
// Dual-port RAM whose two highest words double as cross-port mailboxes.
// Assumes: synchronous active-low reset; the array itself is not reset.
module mbox_dpram
    import mbox_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mb_enable,
    input  logic              l_cs_n,
    input  logic              l_oe_n,
    input  logic              l_we_n,
    input  logic [ADDR_W-1:0] l_addr,
    input  logic [DATA_W-1:0] l_wdata,
    output logic [DATA_W-1:0] l_rdata,
    output logic              l_irq_n,
    input  logic              r_cs_n,
    input  logic              r_oe_n,
    input  logic              r_we_n,
    input  logic [ADDR_W-1:0] r_addr,
    input  logic [DATA_W-1:0] r_wdata,
    output logic [DATA_W-1:0] r_rdata,
    output logic              r_irq_n
);
    localparam int NPORT = 2;   // index 0 = left, 1 = right

    logic [NPORT-1:0]             cs_n, oe_n, we_n;
    logic [NPORT-1:0][ADDR_W-1:0] addr;
    port_op_t [NPORT-1:0]         op;
    logic [NPORT-1:0]             box_lo, box_hi;

    // Gather both ports' pins into indexed vectors for the decoder loop
    always_comb begin
        cs_n = {r_cs_n, l_cs_n};
        oe_n = {r_oe_n, l_oe_n};
        we_n = {r_we_n, l_we_n};
        addr = {r_addr, l_addr};
    end

    for (genvar p = 0; p < NPORT; p++) begin : g_dec
        port_decode #(.AW(ADDR_W)) i_dec (
            .cs_n      (cs_n[p]),
            .oe_n      (oe_n[p]),
            .we_n      (we_n[p]),
            .addr      (addr[p]),
            .op        (op[p]),
            .at_box_lo (box_lo[p]),
            .at_box_hi (box_hi[p])
        );
    end

    dpram_core #(.AW(ADDR_W), .DW(DATA_W)) i_core (
        .clk     (clk),
        .rst_n   (rst_n),
        .l_wr    (op[0].wr),
        .l_rd    (op[0].rd),
        .l_addr  (l_addr),
        .l_wdata (l_wdata),
        .l_rdata (l_rdata),
        .r_wr    (op[1].wr),
        .r_rd    (op[1].rd),
        .r_addr  (r_addr),
        .r_wdata (r_wdata),
        .r_rdata (r_rdata)
    );

    logic l_set, l_clr, r_set, r_clr;

    // Cross-port set and own-port clear terms for the two flags
    always_comb begin
        l_set = op[1].wr     && box_lo[1];
        l_clr = op[0].sel_oe && box_lo[0];
        r_set = op[0].wr     && box_hi[0];
        r_clr = op[1].rd     && box_hi[1];
    end

    mbox_flag i_lflag (
        .clk    (clk),
        .rst_n  (rst_n),
        .enable (mb_enable),
        .set    (l_set),
        .clr    (l_clr),
        .irq_n  (l_irq_n)
    );

    mbox_flag i_rflag (
        .clk    (clk),
        .rst_n  (rst_n),
        .enable (mb_enable),
        .set    (r_set),
        .clr    (r_clr),
        .irq_n  (r_irq_n)
    );
endmodule

// File: rtl/mbox_dpram_chk.sv
// Property checker for mbox_dpram, attached by bind; observes ports only.
module mbox_dpram_chk #(
    parameter int ADDR_W = 10,
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              mb_enable,
    input logic              l_cs_n,
    input logic              l_oe_n,
    input logic              l_we_n,
    input logic [ADDR_W-1:0] l_addr,
    input logic [DATA_W-1:0] l_rdata,
    input logic              l_irq_n,
    input logic              r_cs_n,
    input logic              r_oe_n,
    input logic              r_we_n,
    input logic [ADDR_W-1:0] r_addr,
    input logic [DATA_W-1:0] r_rdata,
    input logic              r_irq_n
);
    localparam logic [ADDR_W-1:0] TOP  = {ADDR_W{1'b1}};
    localparam logic [ADDR_W-1:0] TOP1 = TOP - 1'b1;

    logic ls, lc, rs, rc, rwr_top;
    // Set and clear conditions rebuilt from the pins
    always_comb begin
        ls      = !r_cs_n && !r_we_n && (r_addr == TOP1);
        lc      = !l_cs_n && !l_oe_n && (l_addr == TOP1);
        rs      = !l_cs_n && !l_we_n && (l_addr == TOP);
        rc      = !r_cs_n && r_we_n && !r_oe_n && (r_addr == TOP);
        rwr_top = !r_cs_n && !r_we_n && (r_addr == TOP);
    end

    a_r11_reset_release: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (l_irq_n && r_irq_n && l_rdata == '0 && r_rdata == '0));
    a_r5_left_set: assert property (@(posedge clk) disable iff (!rst_n)
        (mb_enable && ls) |=> !l_irq_n);
    a_r6_left_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (mb_enable && lc && !ls) |=> l_irq_n);
    a_r6_left_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (mb_enable && !lc && !ls) |=> $stable(l_irq_n));
    a_r7_right_set: assert property (@(posedge clk) disable iff (!rst_n)
        (mb_enable && rs) |=> !r_irq_n);
    a_r8_right_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (mb_enable && rc && !rs) |=> r_irq_n);
    a_r8_write_no_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (mb_enable && rwr_top && !rs) |=> $stable(r_irq_n));
    a_r9_set_beats_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (mb_enable && ls && lc) |=> !l_irq_n);
    a_r10_disabled: assert property (@(posedge clk) disable iff (!rst_n)
        !mb_enable |=> (l_irq_n && r_irq_n));
    a_r4_left_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        l_cs_n |=> $stable(l_rdata));
    a_r4_right_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        r_cs_n |=> $stable(r_rdata));
endmodule

bind mbox_dpram mbox_dpram_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .mb_enable (mb_enable),
    .l_cs_n    (l_cs_n),
    .l_oe_n    (l_oe_n),
    .l_we_n    (l_we_n),
    .l_addr    (l_addr),
    .l_rdata   (l_rdata),
    .l_irq_n   (l_irq_n),
    .r_cs_n    (r_cs_n),
    .r_oe_n    (r_oe_n),
    .r_we_n    (r_we_n),
    .r_addr    (r_addr),
    .r_rdata   (r_rdata),
    .r_irq_n   (r_irq_n)
);

// File: tb/test_mbox_dpram.sv
// Bench for mbox_dpram: directed mailbox cases plus seeded random traffic,
// compared each cycle against a behavioural model kept in the bench.
module test_mbox_dpram;
    localparam int AW = 10;
    localparam int DW = 16;
    localparam int DEPTH = 1 << AW;
    localparam logic [AW-1:0] TOP  = {AW{1'b1}};
    localparam logic [AW-1:0] TOP1 = TOP - 1'b1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic mb_enable = 1'b0;
    logic l_cs_n = 1'b1, l_oe_n = 1'b1, l_we_n = 1'b1;
    logic r_cs_n = 1'b1, r_oe_n = 1'b1, r_we_n = 1'b1;
    logic [AW-1:0] l_addr = '0, r_addr = '0;
    logic [DW-1:0] l_wdata = '0, r_wdata = '0;
    logic [DW-1:0] l_rdata, r_rdata;
    logic l_irq_n, r_irq_n;

    always #10 clk = ~clk;   // 50 MHz

    mbox_dpram #(.ADDR_W(AW), .DATA_W(DW)) i_mbox_dpram (
        .clk(clk), .rst_n(rst_n), .mb_enable(mb_enable),
        .l_cs_n(l_cs_n), .l_oe_n(l_oe_n), .l_we_n(l_we_n), .l_addr(l_addr),
        .l_wdata(l_wdata), .l_rdata(l_rdata), .l_irq_n(l_irq_n),
        .r_cs_n(r_cs_n), .r_oe_n(r_oe_n), .r_we_n(r_we_n), .r_addr(r_addr),
        .r_wdata(r_wdata), .r_rdata(r_rdata), .r_irq_n(r_irq_n)
    );

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    logic [DW-1:0] mdl [DEPTH];
    logic [DW-1:0] e_lrd = '0, e_rrd = '0;
    logic e_lirq = 1'b1, e_rirq = 1'b1;

    task automatic chk(input string tag, input string what, input logic [DW-1:0] act,
                       input logic [DW-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic drive(input logic lc, input logic lo, input logic lw,
                         input logic [AW-1:0] la, input logic [DW-1:0] ld,
                         input logic rc, input logic ro, input logic rw,
                         input logic [AW-1:0] ra, input logic [DW-1:0] rd);
        l_cs_n = lc; l_oe_n = lo; l_we_n = lw; l_addr = la; l_wdata = ld;
        r_cs_n = rc; r_oe_n = ro; r_we_n = rw; r_addr = ra; r_wdata = rd;
    endtask

    // Advance one clock: update the model from the driven inputs, then compare
    task automatic tick(input string tag);
        logic lwr, lrd, lclr, rwr, rrd, rclr;
        lwr  = !l_cs_n && !l_we_n;
        lrd  = !l_cs_n && l_we_n && !l_oe_n;
        lclr = !l_cs_n && !l_oe_n && l_addr == TOP1;
        rwr  = !r_cs_n && !r_we_n;
        rrd  = !r_cs_n && r_we_n && !r_oe_n;
        rclr = rrd && r_addr == TOP;
        if (lrd) e_lrd = mdl[l_addr];
        if (rrd) e_rrd = mdl[r_addr];
        if (rwr) mdl[r_addr] = r_wdata;
        if (lwr) mdl[l_addr] = l_wdata;
        if (!mb_enable)                 e_lirq = 1'b1;
        else if (rwr && r_addr == TOP1) e_lirq = 1'b0;
        else if (lclr)                  e_lirq = 1'b1;
        if (!mb_enable)                 e_rirq = 1'b1;
        else if (lwr && l_addr == TOP)  e_rirq = 1'b0;
        else if (rclr)                  e_rirq = 1'b1;
        @(posedge clk);
        #5;
        chk(tag, "l_rdata", l_rdata, e_lrd);
        chk(tag, "r_rdata", r_rdata, e_rrd);
        chk(tag, "l_irq_n", DW'(l_irq_n), DW'(e_lirq));
        chk(tag, "r_irq_n", DW'(r_irq_n), DW'(e_rirq));
    endtask

    task automatic idle();
        drive(1, 1, 1, '0, '0, 1, 1, 1, '0, '0);
    endtask

    function automatic logic [AW-1:0] pick_addr();
        int k = int'($urandom_range(0, 9));
        return (k == 8) ? TOP1 : (k == 9) ? TOP : AW'(k);
    endfunction

    initial begin
        #(20 * 20000);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h1d5e_7a03));
        repeat (3) @(posedge clk);
        #5;
        // R11: reset values
        chk("R11", "l_irq_n", DW'(l_irq_n), DW'(1'b1));
        chk("R11", "r_irq_n", DW'(r_irq_n), DW'(1'b1));
        chk("R11", "l_rdata", l_rdata, '0);
        chk("R11", "r_rdata", r_rdata, '0);
        rst_n = 1'b1;

        // R2 / R10: fill the array from both ports with the mailbox off
        for (int a = 0; a < DEPTH; a += 2)
        begin
            drive(0, 1, 0, AW'(a), DW'(a * 7 + 3), 0, 1, 0, AW'(a + 1), DW'(a * 5 + 1));
            tick("R2");
        end
        // R10 / R12: top words read back as plain data, no interrupt
        drive(0, 0, 1, TOP1, '0, 0, 0, 1, TOP, '0);
        tick("R12");
        chk("R10", "l_irq_n off", DW'(l_irq_n), DW'(1'b1));
        chk("R10", "r_irq_n off", DW'(r_irq_n), DW'(1'b1));

        mb_enable = 1'b1;
        // R5: right writes left inbox
        drive(1, 1, 1, '0, '0, 0, 1, 0, TOP1, 16'hA5A5);
        tick("R5");
        chk("R5", "l_irq_n set", DW'(l_irq_n), DW'(1'b0));
        // R6: left writes its inbox with output enable low -> clears
        drive(0, 0, 0, TOP1, 16'h1234, 1, 1, 1, '0, '0);
        tick("R6");
        chk("R6", "l_irq_n clear", DW'(l_irq_n), DW'(1'b1));
        // R12: mailbox holds the last data
        drive(0, 0, 1, TOP1, '0, 1, 1, 1, '0, '0);
        tick("R12");
        chk("R12", "inbox data", l_rdata, 16'h1234);
        // R7: left writes right inbox
        drive(0, 1, 0, TOP, 16'h0F0F, 1, 1, 1, '0, '0);
        tick("R7");
        chk("R7", "r_irq_n set", DW'(r_irq_n), DW'(1'b0));
        // R8: right write and read with output enable high do not clear
        drive(1, 1, 1, '0, '0, 0, 0, 0, TOP, 16'h7777);
        tick("R8");
        drive(1, 1, 1, '0, '0, 0, 1, 1, TOP, '0);
        tick("R8");
        chk("R8", "r_irq_n kept", DW'(r_irq_n), DW'(1'b0));
        drive(1, 1, 1, '0, '0, 0, 0, 1, TOP, '0);
        tick("R8");
        chk("R8", "r_irq_n clear", DW'(r_irq_n), DW'(1'b1));
        chk("R12", "right inbox data", r_rdata, 16'h7777);
        // R9: set and clear in the same cycle
        drive(0, 0, 1, TOP1, '0, 0, 1, 0, TOP1, 16'hBEEF);
        tick("R9");
        chk("R9", "l_irq_n set wins", DW'(l_irq_n), DW'(1'b0));
        // R4: deselected port with write level stores nothing, no clear
        drive(1, 0, 0, TOP1, 16'hDEAD, 1, 1, 1, '0, '0);
        tick("R4");
        chk("R4", "l_irq_n untouched", DW'(l_irq_n), DW'(1'b0));
        drive(1, 1, 1, '0, '0, 0, 0, 1, TOP1, '0);
        tick("R4");
        chk("R4", "no deselected write", r_rdata, 16'hBEEF);
        // R10: disabling releases the pending interrupt
        mb_enable = 1'b0;
        idle();
        tick("R10");
        chk("R10", "l_irq_n released", DW'(l_irq_n), DW'(1'b1));
        mb_enable = 1'b1;
        // R3: same-address writes, left wins
        drive(0, 1, 0, 10'd5, 16'h1111, 0, 1, 0, 10'd5, 16'h2222);
        tick("R3");
        drive(0, 0, 1, 10'd5, '0, 1, 1, 1, '0, '0);
        tick("R3");
        chk("R3", "left wins", l_rdata, 16'h1111);
        // R2: read during other port's write returns old data
        drive(0, 1, 0, 10'd6, 16'h3333, 0, 0, 1, 10'd6, '0);
        tick("R2");
        chk("R2", "old data", r_rdata, DW'(6 * 7 + 3));
        // R1: plain read one clock later
        drive(1, 1, 1, '0, '0, 0, 0, 1, 10'd6, '0);
        tick("R1");
        chk("R1", "new data", r_rdata, 16'h3333);

        // Random mixed traffic over small and mailbox addresses
        for (int i = 0; i < 4000; i++) begin
            if ($urandom_range(0, 31) == 0) mb_enable = ~mb_enable;
            drive(1'($urandom_range(0, 3) == 0), 1'($urandom), 1'($urandom),
                  pick_addr(), DW'($urandom),
                  1'($urandom_range(0, 3) == 0), 1'($urandom), 1'($urandom),
                  pick_addr(), DW'($urandom));
            tick("R1");
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule